// File: doc/BRIEF.md
# Masked-Write GPIO Bank

This block is a 32-pin general-purpose I/O bank. It is built from four ports of eight pins each and sits on a simple synchronous register bus: one address, a write strobe, write data, and read data that is combinational from the address. For every pin, software picks whether the pad belongs to the GPIO logic, whether the pad is driven, and the value that is driven. Software can also read the synchronized pad level and set up interrupt detection on that pin.

Each writable register (except the clear register) is also reachable through an alias address. A write to an alias changes only the bits chosen by a select byte, so two agents can update different pins of the same port without a read-modify-write. Interrupt detection runs for each pin. It supports rising, falling and both-edge detection, plus level-high and level-low detection. The selected type is held in a 24-bit word with one byte lane per attribute. Pending pins that are enabled are ORed into one bank interrupt output.

The bus is a plain register interface with no back-pressure: every write completes in the cycle its strobe is high, and every read is served combinationally. There is no data stream, so no valid/ready pair is needed.

Top module: `gpio_bank_masked`

## Requirements
- R1: Address bits [3:2] pick the port, so ports sit 4 bytes apart and pin index bits [4:3] give the port and bits [2:0] give the pin. Bits [6:4] pick the register: 0 ownership, 1 drive enable, 2 drive value, 3 input, 4 pending status, 5 interrupt enable, 6 interrupt type, 7 clear. Bit 11 selects the alias. Any address with bits [10:7] non-zero reads zero and writes nothing.
- R2: A plain write loads the register from data [7:0], or from data [23:0] for the type register. Reads return the register zero-extended. The clear register always reads zero.
- R3: In an alias write, data [15:8] select which pins change and data [7:0] give their new values; unselected pins keep their value. For the type register the alias touches only the polarity lane [7:0]. Alias writes to the input or clear register have no effect.
- R4: pad_own equals the ownership register, pad_oe is ownership AND drive enable, and pad_out equals the drive-value register.
- R5: The input register shows each pad through a two-flop synchronizer. A pad change shows in a read after two rising clock edges, and not after one.
- R6: Type bits per pin n are: bit n for polarity (1 = high/rising), bit n+8 for edge mode, bit n+16 for both edges. The codes are: rising = edge+polarity, falling = edge only, both = edge+both, level high = polarity only, level low = all zero.
- R7: In an edge mode, a qualifying edge of the synchronized input sets the pin's status bit. A non-qualifying edge leaves it clear.
- R8: In a level mode, the status bit is set while the level is active. A clear has no effect while the level stays active. The bit stays set after the level goes inactive, until it is cleared.
- R9: Writing 1 to a clear bit clears that status bit, and writing 0 does nothing. If a qualifying event arrives in the same cycle as the clear, the bit stays set.
- R10: bank_irq is the OR over all pins of status AND interrupt enable. A pin whose enable bit is 0 cannot raise it.
- R11: Reset zeroes every register. Because the level-low code is all zeros, pins whose pads are low show status 1 right after reset, while bank_irq stays 0.
- R12: Plain and alias writes to the status register load status bits directly, so software can set or drop them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pad_in | input | 32 | Asynchronous pad levels |
| pad_own | output | 32 | Per-pin select: 1 = pad owned by GPIO logic |
| pad_oe | output | 32 | Per-pin drive enable toward the pad |
| pad_out | output | 32 | Per-pin drive value |
| bank_irq | output | 1 | Combined interrupt of the bank |

## Verification
The assertions assume that bus_addr, bus_wdata and bus_we are settled for the whole cycle in which a write commits. They also assume that pad_in changes no more often than the synchronizer can follow, so that the one-cycle edge comparison sees every transition. The stimulus changes bus signals and pads only on falling clock edges. It holds each pad level for at least five cycles before sampling status or the interrupt. The one exception is a test that deliberately places a clear write on the exact cycle where a detected edge commits.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  localparam int LANE_W = 8;
  localparam int TYPE_W = 3 * LANE_W;

  typedef enum logic [2:0] {
    REG_OWN    = 3'd0,
    REG_DRVEN  = 3'd1,
    REG_DRVVAL = 3'd2,
    REG_SAMPLE = 3'd3,
    REG_PEND   = 3'd4,
    REG_ARM    = 3'd5,
    REG_TRIG   = 3'd6,
    REG_ACK    = 3'd7
  } gpio_reg_e;

  // selected bits take the new value, the others keep the old one
  function automatic logic [LANE_W-1:0] lane_merge(input logic [LANE_W-1:0] old_v,
                                                   input logic [LANE_W-1:0] sel,
                                                   input logic [LANE_W-1:0] val);
    return (old_v & ~sel) | (val & sel);
  endfunction
endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      sync_o <= '0;
    end else begin
      meta_q <= async_i;
      sync_o <= meta_q;
    end
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_bank_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [LANE_W-1:0] pin_s,
  input  logic              wr_en,
  input  logic              wr_alias,
  input  gpio_reg_e         wr_reg,
  input  logic [TYPE_W-1:0] wdata,
  output logic [LANE_W-1:0] own_q,
  output logic [LANE_W-1:0] drv_en_q,
  output logic [LANE_W-1:0] drv_val_q,
  output logic [LANE_W-1:0] arm_q,
  output logic [LANE_W-1:0] pend_q,
  output logic [TYPE_W-1:0] trig_q
);
  logic [LANE_W-1:0] sel, val, prev_q, hit, pend_base;

  assign sel = wdata[2*LANE_W-1:LANE_W];
  assign val = wdata[LANE_W-1:0];

  // per-pin detector: lane 0 polarity, lane 1 edge mode, lane 2 both edges
  always_comb begin
    for (int i = 0; i < LANE_W; i++) begin
      logic pol, edg, bth, rise, fall;
      pol  = trig_q[i];
      edg  = trig_q[i+LANE_W];
      bth  = trig_q[i+2*LANE_W];
      rise = pin_s[i] & ~prev_q[i];
      fall = ~pin_s[i] & prev_q[i];
      if (edg) hit[i] = bth ? (rise | fall) : (pol ? rise : fall);
      else     hit[i] = pol ? pin_s[i] : ~pin_s[i];
    end
  end

  // software update of status first, detection ORed on top so events win
  always_comb begin
    pend_base = pend_q;
    if (wr_en && wr_reg == REG_PEND)
      pend_base = wr_alias ? lane_merge(pend_q, sel, val) : val;
    else if (wr_en && !wr_alias && wr_reg == REG_ACK)
      pend_base = pend_q & ~val;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q     <= '0;
      drv_en_q  <= '0;
      drv_val_q <= '0;
      arm_q     <= '0;
      trig_q    <= '0;
      pend_q    <= '0;
      prev_q    <= '0;
    end else begin
      prev_q <= pin_s;
      pend_q <= pend_base | hit;
      if (wr_en) begin
        case (wr_reg)
          REG_OWN:    own_q     <= wr_alias ? lane_merge(own_q, sel, val) : val;
          REG_DRVEN:  drv_en_q  <= wr_alias ? lane_merge(drv_en_q, sel, val) : val;
          REG_DRVVAL: drv_val_q <= wr_alias ? lane_merge(drv_val_q, sel, val) : val;
          REG_ARM:    arm_q     <= wr_alias ? lane_merge(arm_q, sel, val) : val;
          REG_TRIG:   trig_q    <= wr_alias
                                   ? {trig_q[TYPE_W-1:LANE_W], lane_merge(trig_q[LANE_W-1:0], sel, val)}
                                   : wdata;
          default: ;
        endcase
      end
    end
  end

  // R7 R8 R9
  hit_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit != '0) |=> ((pend_q & $past(hit)) == $past(hit)));

  // R9
  ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_alias && wr_reg == REG_ACK) |=> ((pend_q & $past(val & ~hit)) == '0));

  // R3
  alias_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_alias && wr_reg == REG_OWN) |=> (((own_q ^ $past(own_q)) & ~$past(sel)) == '0));
endmodule

// File: rtl/gpio_bank_masked.sv
module gpio_bank_masked
  import gpio_bank_pkg::*;
#(
  parameter int NPORT = 4,
  parameter int AW    = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [AW-1:0]           bus_addr,
  input  logic                    bus_we,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic [NPORT*LANE_W-1:0] pad_in,
  output logic [NPORT*LANE_W-1:0] pad_own,
  output logic [NPORT*LANE_W-1:0] pad_oe,
  output logic [NPORT*LANE_W-1:0] pad_out,
  output logic                    bank_irq
);
  localparam int PSEL_W = 2;
  localparam int NPIN   = NPORT * LANE_W;

  logic [NPIN-1:0]   pin_s;
  logic              alias_sel, addr_ok;
  logic [PSEL_W-1:0] port_idx;
  gpio_reg_e         reg_idx;
  logic [LANE_W-1:0] own_a [NPORT];
  logic [LANE_W-1:0] den_a [NPORT];
  logic [LANE_W-1:0] dval_a[NPORT];
  logic [LANE_W-1:0] arm_a [NPORT];
  logic [LANE_W-1:0] pend_a[NPORT];
  logic [TYPE_W-1:0] trig_a[NPORT];
  logic [NPORT-1:0]  port_irq, port_armed;
  logic [3:0]        unused_bits;

  assign unused_bits = {bus_addr[1:0], ^bus_wdata[31:TYPE_W], 1'b0};
  assign alias_sel   = bus_addr[AW-1];
  assign addr_ok     = (bus_addr[AW-2:7] == '0) && (int'(bus_addr[3:2]) < NPORT);
  assign port_idx    = bus_addr[3:2];
  assign reg_idx     = gpio_reg_e'(bus_addr[6:4]);

  gpio_sync2 #(.W(NPIN)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_i(pad_in), .sync_o(pin_s)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_port
    gpio_port u_port (
      .clk      (clk),
      .rst_n    (rst_n),
      .pin_s    (pin_s[g*LANE_W +: LANE_W]),
      .wr_en    (bus_we && addr_ok && (port_idx == PSEL_W'(g))),
      .wr_alias (alias_sel),
      .wr_reg   (reg_idx),
      .wdata    (bus_wdata[TYPE_W-1:0]),
      .own_q    (own_a[g]),
      .drv_en_q (den_a[g]),
      .drv_val_q(dval_a[g]),
      .arm_q    (arm_a[g]),
      .pend_q   (pend_a[g]),
      .trig_q   (trig_a[g])
    );
    assign pad_own[g*LANE_W +: LANE_W] = own_a[g];
    assign pad_oe [g*LANE_W +: LANE_W] = own_a[g] & den_a[g];
    assign pad_out[g*LANE_W +: LANE_W] = dval_a[g];
    assign port_irq[g]   = |(pend_a[g] & arm_a[g]);
    assign port_armed[g] = |arm_a[g];
  end

  assign bank_irq = |port_irq;

  always_comb begin
    bus_rdata = '0;
    if (addr_ok) begin
      case (reg_idx)
        REG_OWN:    bus_rdata = 32'(own_a[port_idx]);
        REG_DRVEN:  bus_rdata = 32'(den_a[port_idx]);
        REG_DRVVAL: bus_rdata = 32'(dval_a[port_idx]);
        REG_SAMPLE: bus_rdata = 32'(pin_s[port_idx*LANE_W +: LANE_W]);
        REG_PEND:   bus_rdata = 32'(pend_a[port_idx]);
        REG_ARM:    bus_rdata = 32'(arm_a[port_idx]);
        REG_TRIG:   bus_rdata = 32'(trig_a[port_idx]);
        default:    bus_rdata = '0;
      endcase
    end
  end

  // R10
  irq_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bank_irq |-> (|port_armed));

  // R4
  oe_follows_own_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(|pad_own) |-> !(|pad_oe));
endmodule

// File: tb/gpio_bank_masked_tb_top.sv
module gpio_bank_masked_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_own, pad_oe, pad_out;
  logic        bank_irq;
  int          vecs = 0;
  int          errs = 0;
  bit          done = 1'b0;
  logic [7:0]  sh_own[4], sh_oe[4];

  always #10 clk = ~clk;

  gpio_bank_masked dut_i (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_own(pad_own), .pad_oe(pad_oe), .pad_out(pad_out), .bank_irq(bank_irq)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [11:0] ra(input int port, input int rg, input bit al);
    return 12'((int'(al) << 11) | (rg << 4) | (port << 2));
  endfunction

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    rd(ra(0, 0, 0), d); chk("R11 own after reset", d, 0);
    chk("R11 pad_oe after reset", pad_oe, 0);
    chk("R11 irq after reset", 32'(bank_irq), 0);
    repeat (3) @(negedge clk);
    rd(ra(0, 4, 0), d); chk("R11 level-low status with low pads", d, 32'hff);
    chk("R11 irq stays low", 32'(bank_irq), 0);

    // R1 R2 R3 R4 alias sweep over every select byte
    for (int p = 0; p < 4; p++) begin
      for (int r = 0; r < 4; r++) begin
        int rg;
        logic [7:0] ex;
        rg = (r == 3) ? 5 : r;
        wr(ra(p, rg, 0), 32'hffff_ff5a); ex = 8'h5a;
        rd(ra(p, rg, 0), d); chk("R2 plain write low byte", d, 32'h5a);
        for (int mm = 0; mm < 256; mm++) begin
          logic [7:0] v;
          v = 8'((mm * 37 + 11) & 255);
          wr(ra(p, rg, 1), {16'h0, 8'(mm), v});
          ex = (ex & ~8'(mm)) | (v & 8'(mm));
          rd(ra(p, rg, 0), d); chk("R3 alias merge", d, 32'(ex));
          if (rg == 0) chk("R4 pad_own", 32'(pad_own[p*8 +: 8]), 32'(ex));
          if (rg == 2) chk("R4 pad_out", 32'(pad_out[p*8 +: 8]), 32'(ex));
          if (rg == 1) chk("R4 pad_oe", 32'(pad_oe[p*8 +: 8]), 32'(sh_own[p] & ex));
        end
        if (rg == 0) sh_own[p] = ex;
        if (rg == 1) sh_oe[p] = ex;
      end
      wr(ra(p, 5, 0), 32'h0);
    end
    chk("R4 final pad_oe port0", 32'(pad_oe[7:0]), 32'(sh_own[0] & sh_oe[0]));

    // R1 unmapped and R2 clear read
    rd(12'h080, d); chk("R1 unmapped reads zero", d, 0);
    rd(ra(2, 7, 0), d); chk("R2 clear reads zero", d, 0);

    // R3 type alias touches polarity lane only
    wr(ra(1, 6, 0), 32'h00ab_cdef);
    rd(ra(1, 6, 0), d); chk("R2 type plain 24 bits", d, 32'h00ab_cdef);
    wr(ra(1, 6, 1), {16'h0, 8'h0f, 8'h30});
    rd(ra(1, 6, 0), d); chk("R3 type alias polarity lane", d, 32'h00ab_cde0);

    // R5 input latency
    @(negedge clk) pad_in = 32'hdead_beef;
    rd(ra(3, 3, 0), d); chk("R5 one edge still old", d, 32'h00);
    rd(ra(3, 3, 0), d); chk("R5 two edges new", d, 32'hde);
    wr(ra(0, 3, 1), 32'hffff);
    rd(ra(0, 3, 0), d); chk("R3 input alias ignored", d, 32'hef);
    @(negedge clk) pad_in = '0;
    repeat (4) @(negedge clk);

    // R12 R9 R3 software status and clear rules (port 3 rising, pads idle)
    wr(ra(3, 6, 0), 32'h0000_ffff);
    repeat (3) @(negedge clk);
    wr(ra(3, 4, 0), 32'ha5);
    rd(ra(3, 4, 0), d); chk("R12 plain status load", d, 32'ha5);
    wr(ra(3, 7, 1), 32'hffff);
    rd(ra(3, 4, 0), d); chk("R3 clear alias ignored", d, 32'ha5);
    wr(ra(3, 7, 0), 32'h00);
    rd(ra(3, 4, 0), d); chk("R9 zero clear no effect", d, 32'ha5);
    wr(ra(3, 7, 0), 32'h05);
    rd(ra(3, 4, 0), d); chk("R9 clear ones", d, 32'ha0);
    wr(ra(3, 4, 1), {16'h0, 8'h0f, 8'h03});
    rd(ra(3, 4, 0), d); chk("R12 alias status load", d, 32'ha3);

    // R6 R7 R8 R9 R10 every pin in every detection mode
    for (int n = 0; n < 32; n++) begin
      for (int m = 0; m < 5; m++) begin
        int p, b;
        bit pol, edg, bth, idle, lvl;
        logic [31:0] tw;
        p = n >> 3; b = n & 7;
        case (m)
          0: {pol, edg, bth, idle} = 4'b1100;
          1: {pol, edg, bth, idle} = 4'b0101;
          2: {pol, edg, bth, idle} = 4'b0110;
          3: {pol, edg, bth, idle} = 4'b1000;
          default: {pol, edg, bth, idle} = 4'b0001;
        endcase
        lvl = !edg;
        tw = (32'(pol) << b) | (32'(edg) << (b + 8)) | (32'(bth) << (b + 16));
        @(negedge clk) pad_in = 32'(idle) << n;
        wr(ra(p, 6, 0), tw);
        repeat (5) @(negedge clk);
        wr(ra(p, 7, 0), 32'hff);
        rd(ra(p, 4, 0), d); chk("R6 idle leaves status clear", (d >> b) & 1, 0);
        wr(ra(p, 5, 1), {16'h0, 8'(1 << b), 8'(1 << b)});
        #1 chk("R10 idle irq low", 32'(bank_irq), 0);
        @(negedge clk) pad_in = 32'(!idle) << n;
        repeat (5) @(negedge clk);
        rd(ra(p, 4, 0), d);
        chk(lvl ? "R8 active level sets" : "R7 qualifying edge sets", (d >> b) & 1, 1);
        chk("R10 irq raised", 32'(bank_irq), 1);
        wr(ra(p, 5, 1), {16'h0, 8'(1 << b), 8'h00});
        #1 chk("R10 disabled pin silent", 32'(bank_irq), 0);
        wr(ra(p, 5, 1), {16'h0, 8'(1 << b), 8'(1 << b)});
        wr(ra(p, 7, 0), 32'(1 << b));
        rd(ra(p, 4, 0), d);
        chk(lvl ? "R8 clear blocked while active" : "R9 clear drops edge", (d >> b) & 1, 32'(lvl));
        @(negedge clk) pad_in = 32'(idle) << n;
        repeat (5) @(negedge clk);
        rd(ra(p, 4, 0), d);
        chk(lvl ? "R8 sticky after level ends" : "R7 return edge", (d >> b) & 1, 32'(bth | lvl));
        wr(ra(p, 7, 0), 32'(1 << b));
        rd(ra(p, 4, 0), d); chk("R9 final clear", (d >> b) & 1, 0);
        chk("R10 irq low after clear", 32'(bank_irq), 0);
        wr(ra(p, 5, 0), 32'h0);
      end
    end

    // R9 edge arriving with a clear is kept (pin 0, both edges)
    @(negedge clk) pad_in = '0;
    wr(ra(0, 6, 0), 32'h0001_0100);
    repeat (5) @(negedge clk);
    wr(ra(0, 7, 0), 32'hff);
    @(negedge clk) pad_in = 32'h1;
    repeat (5) @(negedge clk);
    rd(ra(0, 4, 0), d); chk("R9 setup edge seen", d & 1, 1);
    @(negedge clk) pad_in = 32'h0;
    @(negedge clk);
    wr(ra(0, 7, 0), 32'h01);
    rd(ra(0, 4, 0), d); chk("R9 edge wins over clear", d & 1, 1);
    wr(ra(0, 7, 0), 32'h01);
    rd(ra(0, 4, 0), d); chk("R9 later clear works", d & 1, 0);

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule